// File: doc/BRIEF.md
# Microprogram sequencer with bit-OR branching

This block is the control half of a microprogrammed processor. A micro-program counter addresses a read-only control store whose words hold encoded fields. Each field is expanded into individual strobes: a load strobe for one general register, a drive strobe for one general register, a load strobe for one special register, a one-hot ALU operation select, memory read and write requests, carry-in, wait-for-memory and end-of-instruction.

The sequencer picks the next micro-address from one of four sources. It can increment. It can dispatch on the instruction register, where a per-opcode start address has addressing-mode bits ORed into it. It can take the word's own target with the direct/indirect bit ORed into bit 0. It can test the negative flag. An end-of-instruction word returns to the fetch routine at address 0. A word that waits for memory holds its address until memory signals completion.

The control store image and the opcode start-address table are parameters. The integrating design, or a bench, supplies them.

Top module: `useq_ctrl`

## Requirements
- R1: While rst_n is low the micro-address upc_o is 0, and the outputs show the decode of store word 0.
- R2: A word whose sequencing code (bits 1:0) is 00, with end and wait inactive, advances upc_o by one at the next rising edge.
- R3: While the wait bit (bit 3) of the current word is 1 and mfc is 0, upc_o holds and every decoded output stays asserted. Once mfc is 1, sequencing proceeds at the next edge.
- R4: A word with the end bit (bit 2) set and no wait stall sends upc_o to 0 at the next edge, whatever its sequencing code.
- R5: Sequencing code 01 loads a start address looked up by opcode ir[15:12]. In that address, bit 5 is ORed with ir[10], bit 4 is ORed with ir[9], and bit 3 is ORed with (NOT ir[10] AND NOT ir[9] AND ir[8]). The mode in ir[10:9] is 00 register, 01 autoincrement, 10 autodecrement, 11 indexed, and ir[8]=1 means indirect.
- R6: Sequencing code 10 loads the word's next-address field (bits 30:23), with bit 0 ORed with NOT ir[8].
- R7: Sequencing code 11 goes to address 0 when n_flag is 0, and to upc_o+1 when n_flag is 1.
- R8: The register-load (bits 22:19), register-drive (bits 18:15) and special-load (bits 14:11) codes each assert nothing for code 0, and assert only bit k-1 of their output for code k.
- R9: The memory code (bits 6:5) gives 00 no request, 01 mem_rd only, 10 mem_wr only, and 11 no request.
- R10: The ALU code (bits 10:7) asserts only bit k of alu_sel for value k. The carry-in (bit 4), wait (bit 3) and end (bit 2) bits appear unchanged on cin_o, wmfc_o and end_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir | input | 16 | Instruction register contents |
| n_flag | input | 1 | Negative condition flag |
| mfc | input | 1 | Memory operation complete |
| upc_o | output | 8 | Current micro-address |
| reg_ld | output | 15 | One-hot general register load strobes |
| reg_drv | output | 15 | One-hot general register drive strobes |
| oth_ld | output | 15 | One-hot special register load strobes |
| alu_sel | output | 16 | One-hot ALU operation select |
| cin_o | output | 1 | ALU carry-in |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| wmfc_o | output | 1 | Waiting for memory completion |
| end_o | output | 1 | Last word of the instruction |

## Verification
The decoded strobes are combinational from the registered micro-address. They therefore change in the same half cycle as upc_o, and every next-address choice takes effect exactly one rising edge after its inputs are presented. The bench drives ir, n_flag and mfc on the falling edge and samples on the following falling edge. Each sequencing result is thus read one edge after its cause, and the decode of that word is read at the same moment. Multi-step paths such as fetch, dispatch, OR-branch, wait, test and end are walked one edge at a time, with upc_o checked at each step.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;
   typedef enum logic [1:0] {
      SEQ_INC  = 2'b00,
      SEQ_DISP = 2'b01,
      SEQ_ORBR = 2'b10,
      SEQ_COND = 2'b11
   } seq_e;

   localparam logic [1:0] MEM_NOP = 2'b00;
   localparam logic [1:0] MEM_RD  = 2'b01;
   localparam logic [1:0] MEM_WR  = 2'b10;

   // fixed single-bit field positions, low end of the word
   localparam int SEQ_LSB = 0;
   localparam int END_BIT = 2;
   localparam int WAIT_BIT = 3;
   localparam int CIN_BIT = 4;
   localparam int MEM_LSB = 5;
   localparam int ALU_LSB = 7;
endpackage

// File: rtl/useq_store.sv
`timescale 1ns/1ps
module useq_store #(
   parameter int AW = 8,
   parameter int W  = 31,
   parameter logic [(1<<AW)*W-1:0] IMG = '0
) (
   input  logic [AW-1:0] addr,
   output logic [W-1:0]  word
);
   localparam int DEPTH = 1 << AW;

   if (DEPTH < 4) begin : g_chk
      $error("useq_store: control store must hold the fetch routine");
   end

   assign word = IMG[addr*W +: W];
endmodule

// File: rtl/useq_onehot.sv
`timescale 1ns/1ps
module useq_onehot #(
   parameter int CW = 4,
   parameter bit ZERO_IDLE = 1'b1,
   localparam int N = ZERO_IDLE ? (1 << CW) - 1 : (1 << CW)
) (
   input  logic [CW-1:0] code,
   output logic [N-1:0]  sel
);
   if (CW < 1 || CW > 8) begin : g_chk
      $error("useq_onehot: code width out of range");
   end

   for (genvar k = 0; k < N; k++) begin : g_bit
      if (ZERO_IDLE) begin : g_idle
         assign sel[k] = (code == CW'(k + 1));
      end else begin : g_direct
         assign sel[k] = (code == CW'(k));
      end
   end
endmodule

// File: rtl/useq_dispatch.sv
`timescale 1ns/1ps
module useq_dispatch #(
   parameter int UA_W    = 8,
   parameter int OP_W    = 4,
   parameter int DSP_HI  = 5,
   parameter int DSP_LO  = 4,
   parameter int DSP_IND = 3,
   parameter logic [(1<<OP_W)*UA_W-1:0] TABLE = '0
) (
   input  logic [OP_W-1:0] opcode,
   input  logic            mode_hi,
   input  logic            mode_lo,
   input  logic            ind,
   output logic [UA_W-1:0] addr
);
   if (DSP_HI >= UA_W || DSP_LO >= UA_W || DSP_IND >= UA_W) begin : g_chk
      $error("useq_dispatch: OR target bit outside micro-address");
   end

   logic [UA_W-1:0] base;
   logic            reg_ind;

   assign base    = TABLE[opcode*UA_W +: UA_W];
   assign reg_ind = ~mode_hi & ~mode_lo & ind;

   always_comb begin
      addr          = base;
      addr[DSP_HI]  = base[DSP_HI]  | mode_hi;
      addr[DSP_LO]  = base[DSP_LO]  | mode_lo;
      addr[DSP_IND] = base[DSP_IND] | reg_ind;
   end
endmodule

// File: rtl/useq_seq.sv
`timescale 1ns/1ps
module useq_seq
   import useq_pkg::*;
#(
   parameter int UA_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      seq_code,
   input  logic            end_b,
   input  logic            wmfc,
   input  logic            mfc,
   input  logic            n_flag,
   input  logic            ind_bit,
   input  logic [UA_W-1:0] nxt_fld,
   input  logic [UA_W-1:0] disp_addr,
   output logic [UA_W-1:0] upc
);
   localparam logic [UA_W-1:0] FETCH_ADDR = '0;

   seq_e            sc;
   logic            stall;
   logic [UA_W-1:0] upc_inc;
   logic [UA_W-1:0] upc_orb;
   logic [UA_W-1:0] upc_d;

   assign sc      = seq_e'(seq_code);
   assign stall   = wmfc & ~mfc;
   assign upc_inc = upc + 1'b1;
   assign upc_orb = nxt_fld | {{(UA_W-1){1'b0}}, ~ind_bit};

   always_comb begin
      if (stall) begin
         upc_d = upc;
      end else if (end_b) begin
         upc_d = FETCH_ADDR;
      end else begin
         case (sc)
            SEQ_INC:  upc_d = upc_inc;
            SEQ_DISP: upc_d = disp_addr;
            SEQ_ORBR: upc_d = upc_orb;
            SEQ_COND: upc_d = n_flag ? upc_inc : FETCH_ADDR;
            default:  upc_d = upc_inc;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upc <= FETCH_ADDR;
      else        upc <= upc_d;
   end

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wmfc && !mfc) |=> $stable(upc));

   assert_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (end_b && !(wmfc && !mfc)) |=> (upc == '0));

   assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_code == 2'b00 && !end_b && !(wmfc && !mfc)) |=> (upc == $past(upc) + 1'b1));

   assert_cond_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_code == 2'b11 && !end_b && !(wmfc && !mfc) && !n_flag) |=> (upc == '0));

   assert_orbr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_code == 2'b10 && !end_b && !(wmfc && !mfc))
      |=> (upc[UA_W-1:1] == $past(nxt_fld[UA_W-1:1])));
endmodule

// File: rtl/useq_ctrl.sv
`timescale 1ns/1ps
module useq_ctrl
   import useq_pkg::*;
#(
   parameter int UA_W    = 8,
   parameter int RF_W    = 4,
   parameter int OC_W    = 4,
   parameter int AF_W    = 4,
   parameter int IR_W    = 16,
   parameter int OP_LSB  = 12,
   parameter int OP_W    = 4,
   parameter int MODE_HI = 10,
   parameter int MODE_LO = 9,
   parameter int IND_BIT = 8,
   parameter int DSP_HI  = 5,
   parameter int DSP_LO  = 4,
   parameter int DSP_IND = 3,
   parameter logic [(1<<UA_W)*(UA_W+2*RF_W+OC_W+AF_W+7)-1:0] STORE = '0,
   parameter logic [(1<<OP_W)*UA_W-1:0] DISP_BASE = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [IR_W-1:0]       ir,
   input  logic                  n_flag,
   input  logic                  mfc,
   output logic [UA_W-1:0]       upc_o,
   output logic [(1<<RF_W)-2:0]  reg_ld,
   output logic [(1<<RF_W)-2:0]  reg_drv,
   output logic [(1<<OC_W)-2:0]  oth_ld,
   output logic [(1<<AF_W)-1:0]  alu_sel,
   output logic                  cin_o,
   output logic                  mem_rd,
   output logic                  mem_wr,
   output logic                  wmfc_o,
   output logic                  end_o
);
   localparam int UW       = UA_W + 2*RF_W + OC_W + AF_W + 7;
   localparam int OTH_LSB  = ALU_LSB + AF_W;
   localparam int ROUT_LSB = OTH_LSB + OC_W;
   localparam int RIN_LSB  = ROUT_LSB + RF_W;
   localparam int NXT_LSB  = RIN_LSB + RF_W;

   if (OP_LSB + OP_W > IR_W || MODE_HI >= IR_W || MODE_LO >= IR_W || IND_BIT >= IR_W) begin : g_chk_ir
      $error("useq_ctrl: instruction field outside ir");
   end
   if (NXT_LSB + UA_W != UW) begin : g_chk_w
      $error("useq_ctrl: microword layout mismatch");
   end

   logic [UA_W-1:0] upc;
   logic [UW-1:0]   cw;
   logic [UA_W-1:0] disp_addr;

   logic [1:0]      f_seq;
   logic            f_end, f_wait, f_cin;
   logic [1:0]      f_mem;
   logic [AF_W-1:0] f_alu;
   logic [OC_W-1:0] f_oth;
   logic [RF_W-1:0] f_rout, f_rin;
   logic [UA_W-1:0] f_nxt;
   logic            unused_ir;

   useq_store #(.AW(UA_W), .W(UW), .IMG(STORE)) u_store (
      .addr (upc),
      .word (cw)
   );

   assign f_seq  = cw[SEQ_LSB +: 2];
   assign f_end  = cw[END_BIT];
   assign f_wait = cw[WAIT_BIT];
   assign f_cin  = cw[CIN_BIT];
   assign f_mem  = cw[MEM_LSB +: 2];
   assign f_alu  = cw[ALU_LSB +: AF_W];
   assign f_oth  = cw[OTH_LSB +: OC_W];
   assign f_rout = cw[ROUT_LSB +: RF_W];
   assign f_rin  = cw[RIN_LSB +: RF_W];
   assign f_nxt  = cw[NXT_LSB +: UA_W];

   useq_onehot #(.CW(RF_W), .ZERO_IDLE(1'b1)) u_rin  (.code(f_rin),  .sel(reg_ld));
   useq_onehot #(.CW(RF_W), .ZERO_IDLE(1'b1)) u_rout (.code(f_rout), .sel(reg_drv));
   useq_onehot #(.CW(OC_W), .ZERO_IDLE(1'b1)) u_oth  (.code(f_oth),  .sel(oth_ld));
   useq_onehot #(.CW(AF_W), .ZERO_IDLE(1'b0)) u_alu  (.code(f_alu),  .sel(alu_sel));

   always_comb begin
      mem_rd = 1'b0;
      mem_wr = 1'b0;
      case (f_mem)
         MEM_RD:  mem_rd = 1'b1;
         MEM_WR:  mem_wr = 1'b1;
         default: ;
      endcase
   end

   assign cin_o  = f_cin;
   assign wmfc_o = f_wait;
   assign end_o  = f_end;
   assign upc_o  = upc;
   assign unused_ir = ^ir;

   useq_dispatch #(
      .UA_W(UA_W), .OP_W(OP_W), .DSP_HI(DSP_HI), .DSP_LO(DSP_LO),
      .DSP_IND(DSP_IND), .TABLE(DISP_BASE)
   ) u_disp (
      .opcode  (ir[OP_LSB +: OP_W]),
      .mode_hi (ir[MODE_HI]),
      .mode_lo (ir[MODE_LO]),
      .ind     (ir[IND_BIT]),
      .addr    (disp_addr)
   );

   useq_seq #(.UA_W(UA_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .seq_code  (f_seq),
      .end_b     (f_end),
      .wmfc      (f_wait),
      .mfc       (mfc),
      .n_flag    (n_flag),
      .ind_bit   (ir[IND_BIT]),
      .nxt_fld   (f_nxt),
      .disp_addr (disp_addr),
      .upc       (upc)
   );

   assert_rdwr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_ld) && $onehot0(reg_drv) && $onehot0(oth_ld));

   assert_waitstrobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wmfc_o && !mfc) |=> ($stable(mem_rd) && $stable(oth_ld) && wmfc_o));
endmodule

// File: tb/useq_ctrl_bench.sv
`timescale 1ns/1ps
module useq_ctrl_bench;
   localparam int UW = 31;
   localparam int PW = 256 * UW;

   function automatic logic [UW-1:0] mk(input int nxt, input int rin, input int rout,
                                        input int oth, input int alu, input int mem,
                                        input int cin, input int wt, input int en, input int sq);
      logic [UW-1:0] w;
      w = {nxt[7:0], rin[3:0], rout[3:0], oth[3:0], alu[3:0], mem[1:0],
           cin[0], wt[0], en[0], sq[1:0]};
      return w;
   endfunction

   function automatic logic [PW-1:0] build_prog();
      logic [PW-1:0] p;
      p = '0;
      p[0*UW   +: UW] = mk(0, 0, 0, 1, 1, 1, 1, 0, 0, 0);
      p[1*UW   +: UW] = mk(0, 0, 0, 2, 0, 0, 0, 1, 0, 0);
      p[2*UW   +: UW] = mk(0, 0, 0, 3, 0, 0, 0, 0, 0, 0);
      p[3*UW   +: UW] = mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      p[64*UW  +: UW] = mk(170, 0, 0, 0, 0, 0, 0, 0, 0, 2);
      p[72*UW  +: UW] = mk(170, 0, 0, 0, 0, 0, 0, 0, 0, 2);
      p[80*UW  +: UW] = mk(0, 15, 1, 7, 15, 3, 0, 0, 1, 0);
      p[96*UW  +: UW] = mk(0, 0, 0, 0, 0, 2, 1, 0, 1, 0);
      p[112*UW +: UW] = mk(200, 0, 0, 0, 0, 0, 0, 0, 1, 2);
      p[128*UW +: UW] = mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 3);
      p[129*UW +: UW] = mk(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
      p[170*UW +: UW] = mk(0, 0, 0, 4, 0, 1, 0, 1, 0, 0);
      p[171*UW +: UW] = mk(0, 0, 3, 0, 0, 0, 0, 0, 0, 0);
      p[172*UW +: UW] = mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 3);
      p[173*UW +: UW] = mk(0, 5, 0, 0, 3, 2, 0, 0, 1, 0);
      return p;
   endfunction

   function automatic logic [127:0] build_disp();
      logic [127:0] t;
      t = '0;
      t[1*8 +: 8] = 8'd64;
      t[2*8 +: 8] = 8'd128;
      return t;
   endfunction

   localparam logic [PW-1:0]  PROG = build_prog();
   localparam logic [127:0]   DISP = build_disp();

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ir = '0;
   logic        n_flag = 1'b0;
   logic        mfc = 1'b1;
   logic [7:0]  upc_o;
   logic [14:0] reg_ld, reg_drv, oth_ld;
   logic [15:0] alu_sel;
   logic        cin_o, mem_rd, mem_wr, wmfc_o, end_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   useq_ctrl #(.STORE(PROG), .DISP_BASE(DISP)) u_useq_ctrl (
      .clk(clk), .rst_n(rst_n), .ir(ir), .n_flag(n_flag), .mfc(mfc),
      .upc_o(upc_o), .reg_ld(reg_ld), .reg_drv(reg_drv), .oth_ld(oth_ld),
      .alu_sel(alu_sel), .cin_o(cin_o), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .wmfc_o(wmfc_o), .end_o(end_o)
   );

   function automatic logic [15:0] mkir(input int op, input int mode, input int ind);
      return 16'((op << 12) | (mode << 9) | (ind << 8));
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic boot(input logic [15:0] irv);
      rst_n = 1'b0; ir = irv; mfc = 1'b1; n_flag = 1'b0;
      tick(); tick();
      rst_n = 1'b1;
      tick(); tick(); tick();
      chk(upc_o == 8'd3, "R2 fetch reaches dispatch word", upc_o, 3);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; mfc = 1'b1; ir = '0;
      tick(); tick();
      chk(upc_o == 8'd0, "R1 reset address", upc_o, 0);
      chk(mem_rd == 1'b1 && mem_wr == 1'b0, "R1 word 0 read request", mem_rd, 1);
      chk(oth_ld == 15'd1 && alu_sel == 16'd2 && cin_o, "R1 word 0 decode", oth_ld, 1);
      rst_n = 1'b1;
      tick();
      chk(upc_o == 8'd1, "R2 increment 0->1", upc_o, 1);
   endtask

   task automatic t_wait();
      rst_n = 1'b0; mfc = 1'b0; ir = '0;
      tick(); tick();
      rst_n = 1'b1;
      tick();
      chk(upc_o == 8'd1, "R2 increment to wait word", upc_o, 1);
      tick();
      chk(upc_o == 8'd1, "R3 hold while mfc low", upc_o, 1);
      chk(wmfc_o == 1'b1 && oth_ld == 15'd2, "R3 R10 strobes held", oth_ld, 2);
      tick();
      chk(upc_o == 8'd1, "R3 hold second cycle", upc_o, 1);
      mfc = 1'b1;
      tick();
      chk(upc_o == 8'd2, "R3 resume after mfc", upc_o, 2);
      tick();
      chk(upc_o == 8'd3, "R2 increment 2->3", upc_o, 3);
   endtask

   task automatic t_dispatch(input int op, input int mode, input int ind, input int exp);
      boot(mkir(op, mode, ind));
      tick();
      chk(upc_o == 8'(exp), "R5 dispatch target", upc_o, exp);
   endtask

   task automatic t_orbranch_path();
      t_dispatch(1, 0, 0, 64);
      tick();
      chk(upc_o == 8'd171, "R6 direct selects odd target", upc_o, 171);
      chk(reg_drv == 15'd4 && reg_ld == 15'd0, "R8 drive code 3", reg_drv, 4);
      tick();
      chk(upc_o == 8'd172, "R2 step to test word", upc_o, 172);
      n_flag = 1'b0;
      tick();
      chk(upc_o == 8'd0, "R7 N=0 returns to fetch", upc_o, 0);
   endtask

   task automatic t_indirect_path();
      t_dispatch(1, 0, 1, 72);
      tick();
      chk(upc_o == 8'd170, "R6 indirect keeps even target", upc_o, 170);
      mfc = 1'b0;
      tick();
      chk(upc_o == 8'd170, "R3 hold at 170", upc_o, 170);
      chk(mem_rd == 1'b1 && oth_ld == 15'd8, "R3 read held asserted", mem_rd, 1);
      mfc = 1'b1;
      tick();
      chk(upc_o == 8'd171, "R3 resume to 171", upc_o, 171);
      tick();
      n_flag = 1'b1;
      tick();
      chk(upc_o == 8'd173, "R7 N=1 falls through", upc_o, 173);
      chk(reg_ld == 15'd16 && alu_sel == 16'd8, "R8 R10 load code 5 alu 3", reg_ld, 16);
      chk(mem_wr == 1'b1 && mem_rd == 1'b0 && end_o, "R9 write code", mem_wr, 1);
      tick();
      chk(upc_o == 8'd0, "R4 end returns to fetch", upc_o, 0);
   endtask

   task automatic t_decode_edges();
      t_dispatch(1, 1, 0, 80);
      chk(reg_ld == 15'h4000 && reg_drv == 15'd1, "R8 codes 15 and 1", reg_ld, 16384);
      chk(oth_ld == 15'd64 && alu_sel == 16'h8000, "R8 R10 special 7 alu 15", alu_sel, 32768);
      chk(mem_rd == 1'b0 && mem_wr == 1'b0, "R9 code 11 is no request", {mem_rd, mem_wr}, 0);
      chk(cin_o == 1'b0 && end_o == 1'b1, "R10 flag bits", end_o, 1);
      tick();
      chk(upc_o == 8'd0, "R4 end from 80", upc_o, 0);
      t_dispatch(1, 2, 1, 96);
      chk(mem_wr == 1'b1 && mem_rd == 1'b0 && cin_o, "R9 R10 write with carry", mem_wr, 1);
      chk(reg_ld == 15'd0 && oth_ld == 15'd0, "R8 code 0 asserts nothing", reg_ld, 0);
   endtask

   task automatic t_end_priority();
      t_dispatch(1, 3, 1, 112);
      tick();
      chk(upc_o == 8'd0, "R4 end overrides OR-branch", upc_o, 0);
   endtask

   task automatic t_cond_second();
      t_dispatch(2, 0, 0, 128);
      n_flag = 1'b1;
      tick();
      chk(upc_o == 8'd129, "R7 N=1 at 128", upc_o, 129);
      tick();
      chk(upc_o == 8'd0, "R4 end at 129", upc_o, 0);
      t_dispatch(2, 1, 0, 144);
      t_dispatch(2, 0, 0, 128);
      n_flag = 1'b0;
      tick();
      chk(upc_o == 8'd0, "R7 N=0 at 128", upc_o, 0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_wait();
      t_dispatch(1, 0, 0, 64);
      t_dispatch(1, 0, 1, 72);
      t_dispatch(1, 1, 0, 80);
      t_dispatch(1, 2, 1, 96);
      t_dispatch(1, 3, 1, 112);
      t_orbranch_path();
      t_indirect_path();
      t_decode_edges();
      t_end_priority();
      t_cond_second();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule